// File: doc/BRIEF.md
# Predicate-Counted Saturating Scalar Incrementer

This unit takes a vector predicate, finds how many vector elements it marks as active, and adds that number to a signed scalar. The sum is clamped to the largest positive value of the chosen width instead of wrapping. The element size comes from a two-bit code. The arithmetic width is either 32 or 64 bits, chosen by one select bit. In 32-bit operation the upper half of the operand is ignored, and the clamped 32-bit result is sign-extended into the 64-bit output.

The predicate carries one bit per byte of the vector, so its width is the vector length divided by eight. For each element, only the lowest predicate bit of that element's byte group decides whether the element is active. Every other bit in the group is a don't-care. Result, clamp flag and output strobe appear one clock after an input strobe.

Top module: `pred_sat_inc`

## Requirements
- R1: Size code k (0..3) selects elements of 8<<k bits. Element e is active when predicate bit e*(1<<k) is 1. No other predicate bit affects the count.
- R2: With `in_wide`=1, the result is the signed 64-bit operand plus the active-element count, when no clamping is needed.
- R3: With `in_wide`=1, a sum above 2^63-1 gives `out_res`=0x7FFFFFFFFFFFFFFF and `out_sat`=1. Otherwise `out_sat`=0.
- R4: With `in_wide`=0, only operand bits [31:0] are used. Bits [63:32] have no effect on result or flag.
- R5: With `in_wide`=0, a sum above 2^31-1 gives a result of 0x000000007FFFFFFF and `out_sat`=1. Otherwise `out_sat`=0.
- R6: With `in_wide`=0, `out_res[63:32]` equals 32 copies of `out_res[31]`.
- R7: `out_vld` is `in_vld` delayed by one clock. Result and flag reflect the input of the previous strobed cycle. They hold unchanged while `in_vld` is 0.
- R8: While `rst_n` is 0, `out_vld`, `out_sat` and `out_res` are all 0.
- R9: A negative operand never raises `out_sat`. The most negative value of either width plus any count gives the exact sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input strobe |
| in_pred | input | VL_BITS/8 | Predicate, one bit per vector byte |
| in_size | input | 2 | Element size code: 0=8, 1=16, 2=32, 3=64 bits |
| in_op | input | 64 | Scalar operand |
| in_wide | input | 1 | 1 = 64-bit arithmetic, 0 = 32-bit |
| out_vld | output | 1 | Output strobe, one cycle after `in_vld` |
| out_res | output | 64 | Clamped, sign-extended result |
| out_sat | output | 1 | Set when the sum was clamped |

## Verification
The hardest case to reach from the ports is clamping. The count is at most a few hundred, so a random 64-bit or 32-bit operand almost never lies within reach of the positive bound. The stimulus therefore draws part of its operands as the bound minus a small random offset, so sums land on both sides of the limit. Predicate bits that do not govern any element are randomised freely to show they are ignored.

// File: rtl/psi_pkg.sv
package psi_pkg;
    typedef struct packed {
        logic        vld;
        logic        wide;
        logic        sat;
        logic [63:0] res;
    } psi_state_t;
endpackage

// File: rtl/psi_active_count.sv
module psi_active_count #(
    parameter int PW = 256,
    parameter int CW = 9
) (
    input  logic [PW-1:0] pred,
    input  logic [1:0]    size,
    output logic [CW-1:0] cnt
);
    // One governing-bit mask per element size: bit i governs when i is a multiple of the stride
    logic [PW-1:0] gov_mask [4];

    for (genvar s = 0; s < 4; s++) begin : g_size
        for (genvar i = 0; i < PW; i++) begin : g_bit
            assign gov_mask[s][i] = ((i % (1 << s)) == 0);
        end
    end

    logic [PW-1:0] live;

    always_comb begin
        live = pred & gov_mask[size];
        cnt  = '0;
        for (int i = 0; i < PW; i++) begin
            cnt = cnt + CW'(live[i]);
        end
    end
endmodule

// File: rtl/psi_sat_add.sv
module psi_sat_add #(
    parameter int CW = 9
) (
    input  logic [63:0]   op,
    input  logic [CW-1:0] cnt,
    input  logic          wide,
    output logic [63:0]   res,
    output logic          sat
);
    logic [63:0] sum64;
    logic [31:0] sum32;
    logic [31:0] r32;

    always_comb begin
        sum64 = op + {{(64-CW){1'b0}}, cnt};
        sum32 = op[31:0] + {{(32-CW){1'b0}}, cnt};
        r32   = '0;
        if (wide) begin
            // count is non-negative: only a non-negative operand can cross the top
            sat = ~op[63] & sum64[63];
            res = sat ? 64'h7FFF_FFFF_FFFF_FFFF : sum64;
        end else begin
            sat = ~op[31] & sum32[31];
            r32 = sat ? 32'h7FFF_FFFF : sum32;
            res = {{32{r32[31]}}, r32};
        end
    end
endmodule

// File: rtl/pred_sat_inc.sv
module pred_sat_inc #(
    parameter int VL_BITS = 2048
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [VL_BITS/8-1:0] in_pred,
    input  logic [1:0]           in_size,
    input  logic [63:0]          in_op,
    input  logic                 in_wide,
    output logic                 out_vld,
    output logic [63:0]          out_res,
    output logic                 out_sat
);
    import psi_pkg::*;

    localparam int PW = VL_BITS / 8;
    localparam int CW = $clog2(PW + 1);

    logic [CW-1:0] cnt;
    logic [63:0]   sum_res;
    logic          sum_sat;
    psi_state_t    st_d, st_q;

    psi_active_count #(.PW(PW), .CW(CW)) u_count (
        .pred (in_pred),
        .size (in_size),
        .cnt  (cnt)
    );

    psi_sat_add #(.CW(CW)) u_add (
        .op   (in_op),
        .cnt  (cnt),
        .wide (in_wide),
        .res  (sum_res),
        .sat  (sum_sat)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.wide = in_wide;
            st_d.sat  = sum_sat;
            st_d.res  = sum_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_res = st_q.res;
    assign out_sat = st_q.sat;

    assert_vld_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    assert_vld_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_res) && $stable(out_sat)));
    assert_sat_top64_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sat && st_q.wide) |-> out_res == 64'h7FFF_FFFF_FFFF_FFFF);
    assert_sat_top32_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sat && !st_q.wide) |-> out_res == 64'h0000_0000_7FFF_FFFF);
    assert_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.wide |-> out_res[63:32] == {32{out_res[31]}});
    assert_no_neg_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (in_wide ? in_op[63] : in_op[31])) |=> !out_sat);
endmodule

// File: tb/sim_pred_sat_inc.sv
module sim_pred_sat_inc;
    localparam int VL = 2048;
    localparam int PW = VL / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [PW-1:0] in_pred = '0;
    logic [1:0]    in_size = '0;
    logic [63:0]   in_op = '0;
    logic          in_wide = 1'b0;
    logic          out_vld;
    logic [63:0]   out_res;
    logic          out_sat;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pred_sat_inc #(.VL_BITS(VL)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_pred(in_pred),
        .in_size(in_size), .in_op(in_op), .in_wide(in_wide),
        .out_vld(out_vld), .out_res(out_res), .out_sat(out_sat));

    function automatic int count_live(logic [PW-1:0] p, logic [1:0] k);
        int c = 0;
        for (int e = 0; e < PW >> k; e++) if (p[e << k]) c++;
        return c;
    endfunction

    function automatic logic [64:0] model(logic [PW-1:0] p, logic [1:0] k,
                                          logic [63:0] op, logic w);
        logic signed [65:0] s;
        logic signed [65:0] top;
        logic [63:0] r;
        logic f;
        int c = count_live(p, k);
        if (w) begin
            s   = 66'($signed(op)) + 66'(c);
            top = 66'sd9223372036854775807;
        end else begin
            s   = 66'($signed(op[31:0])) + 66'(c);
            top = 66'sd2147483647;
        end
        f = (s > top);
        r = f ? top[63:0] : s[63:0];
        if (!w) r = {{32{r[31]}}, r[31:0]};
        return {f, r};
    endfunction

    task automatic chk(string req, logic [64:0] act, logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run(string req, logic [PW-1:0] p, logic [1:0] k,
                       logic [63:0] op, logic w);
        @(negedge clk);
        in_vld = 1; in_pred = p; in_size = k; in_op = op; in_wide = w;
        @(negedge clk);
        in_vld = 0;
        chk(req, {out_sat, out_res}, model(p, k, op, w));
        chk("R7 valid", {64'd0, out_vld}, 65'd1);
    endtask

    function automatic logic [PW-1:0] rnd_pred();
        logic [PW-1:0] p;
        for (int i = 0; i < PW; i += 32) p[i +: 32] = $urandom;
        return p;
    endfunction

    initial begin
        logic [63:0] held;
        logic [PW-1:0] p;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R8 reset", {out_sat, out_res}, 65'd0);
        chk("R8 reset vld", {64'd0, out_vld}, 65'd0);
        rst_n = 1;

        for (int k = 0; k < 4; k++) begin
            run("R1 all-zero", '0, 2'(k), 64'd100, 1'b1);
            run("R1 all-one", '1, 2'(k), 64'd100, 1'b1);
            run("R1 all-one w32", '1, 2'(k), 64'd5, 1'b0);
        end
        // only non-governing bits set: count must be zero
        for (int k = 1; k < 4; k++) begin
            p = '1;
            for (int e = 0; e < PW >> k; e++) p[e << k] = 1'b0;
            run("R1 nongov", p, 2'(k), 64'd7, 1'b1);
        end
        run("R3 max64", '1, 2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
        run("R3 max64 zero", '0, 2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);
        run("R3 edge64", '1, 2'd0, 64'h7FFF_FFFF_FFFF_FF00, 1'b1);
        run("R5 max32", '1, 2'd3, 64'h0000_0000_7FFF_FFFF, 1'b0);
        run("R5 edge32", '1, 2'd0, 64'h0000_0000_7FFF_FF00, 1'b0);
        run("R9 min64", '1, 2'd0, 64'h8000_0000_0000_0000, 1'b1);
        run("R9 min32", '1, 2'd0, 64'h0000_0000_8000_0000, 1'b0);
        run("R4 upper ignored", '1, 2'd1, 64'hDEAD_BEEF_0000_0010, 1'b0);
        run("R4 upper ignored sat", '1, 2'd0, 64'h1234_5678_7FFF_FFF0, 1'b0);
        run("R6 negative sext", 256'h3, 2'd0, 64'h0000_0000_FFFF_FFF0, 1'b0);
        run("R2 negative wide", '1, 2'd2, 64'hFFFF_FFFF_FFFF_FFF0, 1'b1);

        // R7: result and flag hold while no strobe
        held = out_res;
        @(negedge clk);
        in_op = 64'h1; in_pred = '1;
        @(negedge clk);
        chk("R7 hold", {out_vld, out_res}, {1'b0, held});

        for (int n = 0; n < 400; n++) begin
            logic [63:0] op;
            logic w = 1'($urandom);
            logic [1:0] k = 2'($urandom);
            case ($urandom % 3)
                0: op = {$urandom, $urandom};
                1: op = 64'h7FFF_FFFF_FFFF_FFFF - 64'($urandom % 300);
                default: op = {$urandom, 32'h7FFF_FFFF - 32'($urandom % 300)};
            endcase
            run(w ? "R2 R3 random" : "R4 R5 random", rnd_pred(), k, op, w);
        end

        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule